// File: doc/BRIEF.md
# Tick-Driven Two-Group ADC Scan Sequencer

This block drives an eight-channel successive-approximation converter that digitises four channels per scan. A system tick pulse starts a scan of the first group (channels 0 to 3). When the converter reports completion, the block stores the four lane results and releases its conversion request for one cycle. It then requests the second group (channels 4 to 7). When that scan completes, the second set of results is stored and the block waits for the next tick. Each channel is therefore refreshed once per tick.

The converter delivers each lane as a 16-bit word with a 10-bit sample in its upper bits. The block keeps only bits 15:6, so the stored value is right-aligned. A combinational read port returns any stored channel selected by a 3-bit index. A sticky valid flag tells software when every channel holds a real sample. The lane count, group count, raw width and result width are parameters.

Top module: `adc_scan_seq`

## Requirements
- R1: In idle, a tick sampled high at a clock edge makes `conv_run_o` high with `conv_group_o` = 0 from that edge onward.
- R2: When `conv_done_i` is sampled high while group 0 is converting, `conv_run_o` is low for exactly one cycle. `conv_run_o` then goes high with `conv_group_o` = 1.
- R3: When `conv_done_i` is sampled high while group 1 (the last group) is converting, `conv_run_o` goes low and stays low until a later tick.
- R4: On a completion while converting, lane k of `raw_i` (bits 16k+15 to 16k) is stored as `raw_i[k][15:6]` into slot 4·g+k, where g is the converting group. The other slots keep their values.
- R5: The conversion request `conv_run_o` is cleared on the edge that samples `conv_done_i`, before any new request is issued.
- R6: A tick that arrives while a conversion is running changes neither `conv_run_o` nor `conv_group_o`, and it does not restart the sequence.
- R7: After reset, `conv_run_o` = 0, `valid_o` = 0 and every slot reads 0. `valid_o` rises when the first group-1 completion is stored and stays high.
- R8: `rd_data_o` equals slot `rd_idx_i` in the same cycle, with no clock edge in between.
- R9: A `conv_done_i` pulse while no conversion is running leaves every slot and `conv_run_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | System tick pulse that starts a two-group pass |
| conv_done_i | input | 1 | Converter completion flag, one cycle |
| raw_i | input | 64 | Four 16-bit lane results from the converter |
| rd_idx_i | input | 3 | Channel to read |
| conv_run_o | output | 1 | Conversion request to the converter; a rising edge starts a scan |
| conv_group_o | output | 1 | Channel group of the requested scan |
| rd_data_o | output | 10 | Stored 10-bit value of the selected channel |
| valid_o | output | 1 | Every channel has been converted at least once |

## Verification
The assertions assume that the converter raises `conv_done_i` only as a single-cycle pulse. They also assume that a tick is not meaningful in the same cycle that a completion is sampled. The bench's converter model meets both conditions. It waits for a rising request and holds the request for a random 2 to 40 cycles. It then pulses completion for one cycle, and it drops completion again before it checks anything. Ticks during a conversion and completion pulses while idle are injected on purpose, apart from these rules, to exercise R6 and R9.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_CONV = 2'd1,
        SEQ_GAP  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             done_i,
    output logic             run_o,
    output logic [GRP_W-1:0] group_o,
    output logic             cap_en_o,
    output logic [GRP_W-1:0] cap_group_o,
    output logic             valid_o
);

    localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(NUM_GROUPS - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [GRP_W-1:0] group;
        logic             valid;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.state)
            SEQ_IDLE: begin
                if (tick_i) begin
                    ctrl_d.state = SEQ_CONV;
                    ctrl_d.group = '0;
                end
            end
            SEQ_CONV: begin
                if (done_i) begin
                    if (ctrl_q.group == LAST_GRP) begin
                        ctrl_d.state = SEQ_IDLE;
                        ctrl_d.valid = 1'b1;
                    end else begin
                        ctrl_d.state = SEQ_GAP;
                        ctrl_d.group = ctrl_q.group + 1'b1;
                    end
                end
            end
            SEQ_GAP: begin
                ctrl_d.state = SEQ_CONV;
            end
            default: begin
                ctrl_d.state = SEQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: SEQ_IDLE, group: '0, valid: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign run_o       = (ctrl_q.state == SEQ_CONV);
    assign group_o     = ctrl_q.group;
    assign cap_en_o    = (ctrl_q.state == SEQ_CONV) && done_i;
    assign cap_group_o = ctrl_q.group;
    assign valid_o     = ctrl_q.valid;

endmodule

// File: rtl/adc_seq_store.sv
module adc_seq_store #(
    parameter int NUM_LANES  = 4,
    parameter int NUM_GROUPS = 2,
    parameter int RAW_W      = 16,
    parameter int RES_W      = 10,
    localparam int NUM_CH    = NUM_LANES * NUM_GROUPS,
    localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int SHIFT     = RAW_W - RES_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cap_en_i,
    input  logic [GRP_W-1:0]                  cap_group_i,
    input  logic [NUM_LANES-1:0][RAW_W-1:0]   raw_i,
    output logic [NUM_CH-1:0][RES_W-1:0]      slot_o
);

    typedef struct packed {
        logic [NUM_CH-1:0][RES_W-1:0] slot;
    } store_s;

    store_s store_d, store_q;

    logic [NUM_CH-1:0]            wr_en;
    logic [NUM_CH-1:0][RES_W-1:0] wr_val;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
            assign wr_en[g*NUM_LANES+l]  = cap_en_i && (cap_group_i == GRP_W'(g));
            assign wr_val[g*NUM_LANES+l] = RES_W'(raw_i[l] >> SHIFT);
        end
    end

    always_comb begin
        store_d = store_q;
        for (int c = 0; c < NUM_CH; c++) begin
            if (wr_en[c]) begin
                store_d.slot[c] = wr_val[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

    assign slot_o = store_q.slot;

endmodule

// File: rtl/adc_seq_rdmux.sv
module adc_seq_rdmux #(
    parameter int NUM_CH = 8,
    parameter int RES_W  = 10,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0][RES_W-1:0] slot_i,
    input  logic [IDX_W-1:0]             idx_i,
    output logic [RES_W-1:0]             data_o
);

    always_comb begin
        data_o = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (idx_i == IDX_W'(c)) begin
                data_o = slot_i[c];
            end
        end
    end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
    parameter int NUM_LANES  = 4,
    parameter int NUM_GROUPS = 2,
    parameter int RAW_W      = 16,
    parameter int RES_W      = 10,
    localparam int NUM_CH    = NUM_LANES * NUM_GROUPS,
    localparam int IDX_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            tick_i,
    input  logic                            conv_done_i,
    input  logic [NUM_LANES-1:0][RAW_W-1:0] raw_i,
    input  logic [IDX_W-1:0]                rd_idx_i,
    output logic                            conv_run_o,
    output logic [GRP_W-1:0]                conv_group_o,
    output logic [RES_W-1:0]                rd_data_o,
    output logic                            valid_o
);

    logic                         cap_en;
    logic [GRP_W-1:0]             cap_group;
    logic [NUM_CH-1:0][RES_W-1:0] slots;

    adc_seq_ctrl #(
        .NUM_GROUPS (NUM_GROUPS)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .done_i      (conv_done_i),
        .run_o       (conv_run_o),
        .group_o     (conv_group_o),
        .cap_en_o    (cap_en),
        .cap_group_o (cap_group),
        .valid_o     (valid_o)
    );

    adc_seq_store #(
        .NUM_LANES  (NUM_LANES),
        .NUM_GROUPS (NUM_GROUPS),
        .RAW_W      (RAW_W),
        .RES_W      (RES_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_en_i    (cap_en),
        .cap_group_i (cap_group),
        .raw_i       (raw_i),
        .slot_o      (slots)
    );

    adc_seq_rdmux #(
        .NUM_CH (NUM_CH),
        .RES_W  (RES_W)
    ) u_rdmux (
        .slot_i (slots),
        .idx_i  (rd_idx_i),
        .data_o (rd_data_o)
    );

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
    parameter int NUM_GROUPS = 2,
    parameter int GRP_W      = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             conv_done_i,
    input logic             conv_run_o,
    input logic [GRP_W-1:0] conv_group_o,
    input logic             valid_o
);

    localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(NUM_GROUPS - 1);

    // R5: request drops right after a completion is seen
    assert_run_clear_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_run_o && conv_done_i |=> !conv_run_o);

    // R6: while converting, ticks neither drop nor retarget the request
    assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_run_o && !conv_done_i |=> conv_run_o && $stable(conv_group_o));

    // R2: a non-final group completion leads to the next request after one idle cycle
    assert_next_group_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_run_o && conv_done_i && (conv_group_o != LAST_GRP) |=> ##1 conv_run_o);

    // R1: a fresh group-0 request must come from a tick
    assert_group0_from_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_run_o) && (conv_group_o == '0) |-> $past(tick_i));

    // R2: a later-group request follows a completion two cycles earlier
    assert_later_group_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_run_o) && (conv_group_o != '0) |-> $past(conv_done_i, 2));

    // R7: valid is sticky
    assert_valid_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);

    // R7: valid rises only on the last-group completion
    assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(conv_run_o && conv_done_i && (conv_group_o == LAST_GRP)));

endmodule

bind adc_scan_seq adc_scan_seq_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .GRP_W      (GRP_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .conv_done_i  (conv_done_i),
    .conv_run_o   (conv_run_o),
    .conv_group_o (conv_group_o),
    .valid_o      (valid_o)
);

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/1ps
module adc_scan_seq_tb;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_i = 1'b0;
    logic             conv_done_i = 1'b0;
    logic [3:0][15:0] raw_i = '0;
    logic [2:0]       rd_idx_i = '0;
    logic             conv_run_o;
    logic [0:0]       conv_group_o;
    logic [9:0]       rd_data_o;
    logic             valid_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [9:0] exp_slot [8];

    always #2 clk = ~clk;

    adc_scan_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .conv_done_i  (conv_done_i),
        .raw_i        (raw_i),
        .rd_idx_i     (rd_idx_i),
        .conv_run_o   (conv_run_o),
        .conv_group_o (conv_group_o),
        .rd_data_o    (rd_data_o),
        .valid_o      (valid_o)
    );

    function automatic logic [9:0] expect_val(input logic [15:0] raw);
        return raw[15:6];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_slots(input string req);
        for (int c = 0; c < 8; c++) begin
            rd_idx_i = 3'(c);
            #0.5;
            chk(req, 32'(rd_data_o), 32'(exp_slot[c]));
        end
    endtask

    task automatic complete_group(input int g, input logic [3:0][15:0] vals);
        raw_i = vals;
        conv_done_i = 1'b1;
        for (int l = 0; l < 4; l++) exp_slot[g*4+l] = expect_val(vals[l]);
        @(negedge clk);
        conv_done_i = 1'b0;
        raw_i = {$urandom, $urandom};
        chk("R5 request cleared after done", 32'(conv_run_o), 32'd0);
    endtask

    task automatic do_pass(input logic [3:0][15:0] v0, input logic [3:0][15:0] v1,
                           input int d0, input int d1, input bit extra_tick);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        chk("R1 run after tick", 32'(conv_run_o), 32'd1);
        chk("R1 group 0 after tick", 32'(conv_group_o), 32'd0);
        for (int i = 0; i < d0; i++) begin
            tick_i = extra_tick && (i == 1);
            @(negedge clk);
            tick_i = 1'b0;
            if (extra_tick && i == 1) begin
                chk("R6 run kept on busy tick", 32'(conv_run_o), 32'd1);
                chk("R6 group kept on busy tick", 32'(conv_group_o), 32'd0);
            end
        end
        complete_group(0, v0);
        @(negedge clk);
        chk("R2 run for group 1", 32'(conv_run_o), 32'd1);
        chk("R2 group 1 selected", 32'(conv_group_o), 32'd1);
        check_slots("R4 group 0 slots");
        for (int i = 0; i < d1; i++) begin
            tick_i = extra_tick && (i == 0);
            @(negedge clk);
            tick_i = 1'b0;
            if (extra_tick && i == 0)
                chk("R6 group 1 kept on busy tick", 32'(conv_group_o), 32'd1);
        end
        complete_group(1, v1);
        chk("R7 valid after pass", 32'(valid_o), 32'd1);
        check_slots("R4 all slots after pass");
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R3 idle until next tick", 32'(conv_run_o), 32'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int c = 0; c < 8; c++) exp_slot[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset run", 32'(conv_run_o), 32'd0);
        chk("R7 reset valid", 32'(valid_o), 32'd0);
        check_slots("R7 reset slots");

        // done while idle: nothing captured (R9)
        raw_i = {4{16'hFFC0}};
        conv_done_i = 1'b1;
        @(negedge clk);
        conv_done_i = 1'b0;
        @(negedge clk);
        chk("R9 run after idle done", 32'(conv_run_o), 32'd0);
        check_slots("R9 slots after idle done");

        // first pass, directed boundary values; valid low mid-pass (R7)
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        chk("R1 first run", 32'(conv_run_o), 32'd1);
        repeat (4) @(negedge clk);
        complete_group(0, {16'h003F, 16'h0040, 16'hFFC0, 16'hFFFF});
        chk("R7 valid low after group 0", 32'(valid_o), 32'd0);
        @(negedge clk);
        chk("R2 group 1 after gap", 32'(conv_group_o), 32'd1);
        check_slots("R4 boundary group 0");
        repeat (3) @(negedge clk);
        complete_group(1, {16'h8000, 16'h7FC0, 16'h1234, 16'h0001});
        chk("R7 valid rises", 32'(valid_o), 32'd1);
        check_slots("R4 boundary group 1");

        // done while idle after data present (R9)
        raw_i = '0;
        conv_done_i = 1'b1;
        @(negedge clk);
        conv_done_i = 1'b0;
        @(negedge clk);
        check_slots("R9 slots kept");
        chk("R9 run stays low", 32'(conv_run_o), 32'd0);

        // read port combinational (R8): change index between edges
        @(negedge clk);
        #0.5 rd_idx_i = 3'd6;
        #0.5 chk("R8 same-cycle read 6", 32'(rd_data_o), 32'(exp_slot[6]));
        rd_idx_i = 3'd1;
        #0.5 chk("R8 same-cycle read 1", 32'(rd_data_o), 32'(exp_slot[1]));

        do_pass({4{16'hA5C0}}, {4{16'h5A40}}, 6, 6, 1'b1);
        for (int p = 0; p < 12; p++) begin
            do_pass({$urandom, $urandom}, {$urandom, $urandom},
                    2 + int'($urandom % 39), 2 + int'($urandom % 39), bit'($urandom % 2));
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule